// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block produces the horizontal and vertical timing of a character-based video controller that runs at the CPU clock rate. A cycle counter steps through each raster line and a line counter steps through each frame. The line length and the frame height follow the selected television standard: 71 cycles by 312 lines for the 50 Hz standard, and 65 cycles by 261 lines for the 60 Hz standard. When interlace is enabled in 60 Hz mode, frames alternate between 262 and 263 lines.

Next to the live counters, the block keeps a readable raster register that holds the line number halved, so it steps once per pair of lines. The register is loaded at a fixed cycle of the line, and that cycle depends on the standard. In 50 Hz mode the load falls inside horizontal blanking. In 60 Hz mode it falls at the middle of the line.

Software and timing loops that watch this register depend on that exact load point. The block also drives a one-cycle frame start pulse and level blanking strobes for the pixel and colour logic around it. The standard select and the interlace enable take effect only at a frame boundary, so a frame never changes shape partway through.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low, `cycle`, `line` and `raster` read 0 and the standard and interlace inputs are loaded directly.
- R2: `cycle` counts 0 to 70 in 50 Hz mode (`pal_sel`=1) and 0 to 64 in 60 Hz mode (`pal_sel`=0), then returns to 0.
- R3: `line` increments by one in the cycle after `cycle` reaches its last value, and holds at every other cycle.
- R4: A 60 Hz frame without interlace has 261 lines (0 to 260).
- R5: A 60 Hz frame with interlace has 262 lines in the first interlaced frame, then 263, then 262, and so on. The sequence restarts at 262 whenever interlaced 60 Hz operation newly takes effect.
- R6: A 50 Hz frame has 312 lines whatever the value of `ilace_en`.
- R7: `pal_sel` and `ilace_en` are sampled only at the edge where both counters wrap to zero. Changes at any other time have no effect on the current frame.
- R8: `raster` becomes `line`/2 one cycle after `cycle` equals 66 in 50 Hz mode, or 32 in 60 Hz mode. Otherwise it holds.
- R9: `frame_start` is high exactly while `cycle` and `line` are both 0.
- R10: `hblank` is high during the last 10 cycles of every line.
- R11: `vblank` is high during lines 0 to 7 of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pal_sel | input | 1 | 1 selects 50 Hz timing, 0 selects 60 Hz timing |
| ilace_en | input | 1 | Interlace enable, used in 60 Hz mode |
| cycle | output | 7 | Cycle position within the line |
| line | output | 9 | Line position within the frame |
| raster | output | 8 | Readable double-line raster value |
| frame_start | output | 1 | High in the first cycle of each frame |
| hblank | output | 1 | Horizontal blanking level |
| vblank | output | 1 | Vertical blanking level |

## Verification
The frame wrap can coincide with a change of standard, and the new frame must take its length and its raster load point from the newly sampled inputs, never from a mix of old and new. The bench provokes this by flipping `pal_sel` and `ilace_en` on the final cycle of a frame, and again at random points mid-frame. A reference model steps every cycle and checks the counters, the raster register and both strobes. Frame lengths measured between `frame_start` pulses are compared with the lengths the requirements give for the mode in force.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Timing mode in force for the current frame.
    typedef struct packed {
        logic pal;    // 1: 50 Hz timing, 0: 60 Hz timing
        logic ilace;  // interlace requested
        logic field;  // odd field of an interlaced 60 Hz pair
    } mode_t;

endpackage

// File: rtl/raster_mode_ctl.sv
module raster_mode_ctl
    import raster_pkg::*;
#(
    parameter int PAL_CYCLES  = 71,
    parameter int NTSC_CYCLES = 65,
    parameter int PAL_LINES   = 312,
    parameter int NTSC_LINES  = 261,
    parameter int PAL_UPD     = 66,
    parameter int NTSC_UPD    = 32,
    parameter int CYC_W       = 7,
    parameter int LINE_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_sel,
    input  logic              ilace_en,
    input  logic              frame_wrap,
    output logic [CYC_W-1:0]  last_cycle,
    output logic [LINE_W-1:0] last_line,
    output logic [CYC_W-1:0]  upd_cycle
);

    mode_t st_d, st_q;
    logic  keep_ilace;
    logic [LINE_W-1:0] ntsc_last;

    always_comb begin
        st_d       = st_q;
        keep_ilace = !pal_sel && ilace_en && !st_q.pal && st_q.ilace;
        if (frame_wrap) begin
            st_d.pal   = pal_sel;
            st_d.ilace = ilace_en;
            st_d.field = keep_ilace ? ~st_q.field : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pal   <= pal_sel;
            st_q.ilace <= ilace_en;
            st_q.field <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ntsc_last = LINE_W'(NTSC_LINES - 1);
        if (st_q.ilace)
            ntsc_last = ntsc_last + LINE_W'(1) + {{(LINE_W-1){1'b0}}, st_q.field};
        last_cycle = st_q.pal ? CYC_W'(PAL_CYCLES - 1) : CYC_W'(NTSC_CYCLES - 1);
        last_line  = st_q.pal ? LINE_W'(PAL_LINES - 1) : ntsc_last;
        upd_cycle  = st_q.pal ? CYC_W'(PAL_UPD) : CYC_W'(NTSC_UPD);
    end

    // R7
    mode_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.pal) || !$stable(st_q.ilace)) |-> $past(frame_wrap));

endmodule

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int CYC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] last_cycle,
    output logic [CYC_W-1:0] cycle,
    output logic             line_end
);

    logic [CYC_W-1:0] cyc_d, cyc_q;

    always_comb begin
        line_end = (cyc_q == last_cycle);
        cyc_d    = line_end ? '0 : cyc_q + CYC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    assign cycle = cyc_q;

    // R2
    cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q <= last_cycle);

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [LINE_W-1:0] last_line,
    output logic [LINE_W-1:0] line,
    output logic              frame_wrap
);

    logic [LINE_W-1:0] line_d, line_q;

    always_comb begin
        frame_wrap = line_end && (line_q == last_line);
        line_d     = line_q;
        if (line_end)
            line_d = frame_wrap ? '0 : line_q + LINE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign line = line_q;

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_q) |-> $past(line_end));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= last_line);

endmodule

// File: rtl/raster_readout.sv
module raster_readout #(
    parameter int CYC_W  = 7,
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cycle,
    input  logic [CYC_W-1:0]  upd_cycle,
    input  logic [LINE_W-1:0] line,
    output logic [LINE_W-2:0] raster
);

    logic [LINE_W-2:0] rast_d, rast_q;

    always_comb begin
        rast_d = rast_q;
        if (cycle == upd_cycle)
            rast_d = line[LINE_W-1:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rast_q <= '0;
        else        rast_q <= rast_d;
    end

    assign raster = rast_q;

    // R8
    raster_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rast_q) |-> $past(cycle == upd_cycle));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int PAL_CYCLES    = 71,
    parameter int NTSC_CYCLES   = 65,
    parameter int PAL_LINES     = 312,
    parameter int NTSC_LINES    = 261,
    parameter int PAL_UPD       = 66,
    parameter int NTSC_UPD      = 32,
    parameter int HBLANK_CYCLES = 10,
    parameter int VBLANK_LINES  = 8,
    localparam int MAX_CYC   = (PAL_CYCLES > NTSC_CYCLES) ? PAL_CYCLES : NTSC_CYCLES,
    localparam int MAX_LINES = (PAL_LINES > NTSC_LINES + 2) ? PAL_LINES : NTSC_LINES + 2,
    localparam int CYC_W     = $clog2(MAX_CYC),
    localparam int LINE_W    = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_sel,
    input  logic              ilace_en,
    output logic [CYC_W-1:0]  cycle,
    output logic [LINE_W-1:0] line,
    output logic [LINE_W-2:0] raster,
    output logic              frame_start,
    output logic              hblank,
    output logic              vblank
);

    logic [CYC_W-1:0]  last_cycle, upd_cycle;
    logic [LINE_W-1:0] last_line;
    logic              line_end, frame_wrap;

    raster_mode_ctl #(
        .PAL_CYCLES (PAL_CYCLES),
        .NTSC_CYCLES(NTSC_CYCLES),
        .PAL_LINES  (PAL_LINES),
        .NTSC_LINES (NTSC_LINES),
        .PAL_UPD    (PAL_UPD),
        .NTSC_UPD   (NTSC_UPD),
        .CYC_W      (CYC_W),
        .LINE_W     (LINE_W)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .pal_sel   (pal_sel),
        .ilace_en  (ilace_en),
        .frame_wrap(frame_wrap),
        .last_cycle(last_cycle),
        .last_line (last_line),
        .upd_cycle (upd_cycle)
    );

    raster_hcount #(.CYC_W(CYC_W)) u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_cycle(last_cycle),
        .cycle     (cycle),
        .line_end  (line_end)
    );

    raster_vcount #(.LINE_W(LINE_W)) u_vcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .last_line (last_line),
        .line      (line),
        .frame_wrap(frame_wrap)
    );

    raster_readout #(.CYC_W(CYC_W), .LINE_W(LINE_W)) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .cycle    (cycle),
        .upd_cycle(upd_cycle),
        .line     (line),
        .raster   (raster)
    );

    always_comb begin
        frame_start = (cycle == '0) && (line == '0);
        hblank      = cycle >= (last_cycle - CYC_W'(HBLANK_CYCLES - 1));
        vblank      = line < LINE_W'(VBLANK_LINES);
    end

    // R9
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R10
    hblank_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank) |-> (cycle == '0));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pal_sel = 1'b1;
    logic       ilace_en = 1'b0;
    logic [6:0] cycle;
    logic [8:0] line;
    logic [7:0] raster;
    logic       frame_start, hblank, vblank;

    raster_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .ilace_en(ilace_en),
        .cycle(cycle), .line(line), .raster(raster),
        .frame_start(frame_start), .hblank(hblank), .vblank(vblank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int m_cyc = 0, m_line = 0, m_rast = 0;
    bit m_pal = 1, m_il = 0, m_field = 0;

    function automatic int f_len(bit p);
        return p ? 71 : 65;
    endfunction
    function automatic int f_lines(bit p, bit il, bit fld);
        return p ? 312 : (il ? 262 + int'(fld) : 261);
    endfunction
    function automatic int f_upd(bit p);
        return p ? 66 : 32;
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_line = 0; m_rast = 0;
            m_pal = pal_sel; m_il = ilace_en; m_field = 0;
        end else begin
            if (m_cyc == f_upd(m_pal)) m_rast = m_line / 2;
            if (m_cyc == f_len(m_pal) - 1) begin
                m_cyc = 0;
                if (m_line == f_lines(m_pal, m_il, m_field) - 1) begin
                    m_line = 0;
                    m_field = (!pal_sel && ilace_en && !m_pal && m_il) ? !m_field : 1'b0;
                    m_pal = pal_sel;
                    m_il = ilace_en;
                end else begin
                    m_line++;
                end
            end else begin
                m_cyc++;
            end
        end
    end

    // per-cycle comparison and frame length measurement
    int    frm_cnt = 0, frm_exp = 0;
    string frm_tag = "";
    bit    frm_open = 0;

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check(cycle == 0 && line == 0 && raster == 0, "R1 reset counters",
                      int'(cycle) + int'(line) + int'(raster), 0);
            end else begin
                check(int'(cycle) == m_cyc, "R2 cycle", int'(cycle), m_cyc);
                check(int'(line) == m_line, "R3 line", int'(line), m_line);
                check(int'(raster) == m_rast, "R8 raster", int'(raster), m_rast);
                check(frame_start == (m_cyc == 0 && m_line == 0), "R9 frame_start",
                      int'(frame_start), int'(m_cyc == 0 && m_line == 0));
                check(hblank == (m_cyc >= f_len(m_pal) - 10), "R10 hblank",
                      int'(hblank), int'(m_cyc >= f_len(m_pal) - 10));
                check(vblank == (m_line < 8), "R11 vblank", int'(vblank), int'(m_line < 8));
                frm_cnt++;
                if (frame_start) begin
                    if (frm_open)
                        check(frm_cnt == frm_exp, frm_tag, frm_cnt, frm_exp);
                    frm_open = 1;
                    frm_cnt  = 0;
                    frm_exp  = f_len(m_pal) * f_lines(m_pal, m_il, m_field);
                    frm_tag  = m_pal ? "R6 R7 frame length 50Hz" :
                               (m_il ? "R5 R7 frame length interlaced" : "R4 R7 frame length 60Hz");
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WATCHDOG && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", wd, WATCHDOG);
            finish_run();
        end
    end

    task automatic wait_frame_end();
        // stops on the negedge of the final cycle of the current frame
        do @(negedge clk); while (!(line != 0 && cycle == 0 && 1'b0) &&
                                  !(int'(cycle) == f_len(m_pal) - 1 &&
                                    int'(line) == f_lines(m_pal, m_il, m_field) - 1));
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R6 R7: 50 Hz frame with interlace toggled mid-frame
        repeat (6) begin
            repeat (1000 + ($urandom % 2000)) @(negedge clk);
            ilace_en = $urandom % 2;
        end
        // switch standard exactly on the last cycle of the frame
        wait_frame_end();
        pal_sel = 1'b0; ilace_en = 1'b1;
        // R5: three interlaced frames 262/263/262
        repeat (3) begin
            @(negedge clk);
            wait_frame_end();
        end
        ilace_en = 1'b0;      // R4: next frame is 261 lines
        @(negedge clk);
        wait_frame_end();
        // R7: random mid-frame changes of both inputs
        repeat (25) begin
            repeat (500 + ($urandom % 2000)) @(negedge clk);
            pal_sel  = $urandom % 2;
            ilace_en = $urandom % 2;
        end
        @(negedge clk);
        wait_frame_end();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule